// File: doc/BRIEF.md
# Load-Linked / Store-Conditional Reservation Unit

This unit holds the reservation state that one processor needs for load-linked and store-conditional atomics. A load-linked request reads a word or doubleword through the memory port and records its address as the reservation, marking it valid. A later store-conditional first has its alignment checked. If aligned, its address is compared exactly against the reservation. The store goes to memory only when the reservation is valid and the addresses match. A 1 or 0 success flag is returned either way.

A misaligned store-conditional does not touch memory or the result path. It raises a one-cycle store address-error pulse and captures the offending address. An external clear input, driven for example on an exception return, drops the reservation. Requests may arrive every cycle. The memory port is driven combinationally from the request. Responses and exceptions appear one cycle after the request.

Top module: `llsc_resv_unit`

## Requirements
- R1: After reset `rsp_valid`, `exc_pulse` and `bad_addr` are 0 and the reservation is invalid, so a store-conditional issued before any load-linked returns 0 and does not write memory.
- R2: A load-linked (`req_sc`=0) drives `mem_req`=1, `mem_we`=0, `mem_addr`=`req_addr` and `mem_dbl`=`req_dbl` in the request cycle. In the next cycle `rsp_valid`=1 and `rsp_data` carries `mem_rdata`: all 64 bits for a doubleword, or bits 31:0 sign-extended to 64 bits for a word (upper input bits ignored).
- R3: A load-linked stores its address as the reservation and marks it valid.
- R4: A word store-conditional (`req_sc`=1, `req_dbl`=0) with `req_addr[1:0]`≠0 drives no memory request. One cycle later `exc_pulse`=1 for one cycle, `bad_addr` holds the address, and `rsp_valid` stays 0. The reservation is left unchanged.
- R5: A doubleword store-conditional (`req_dbl`=1) is misaligned when `req_addr[2:0]`≠0, with the same effects as R4. A word store-conditional at an address with only bit 2 set is aligned.
- R6: An aligned store-conditional whose address equals a valid reservation drives `mem_req`=1 and `mem_we`=1 with the request's address, data and size. It returns `rsp_data`=1 in the next cycle.
- R7: An aligned store-conditional with a mismatched address or an invalid reservation drives no memory request. It returns `rsp_data`=0 in the next cycle.
- R8: Every aligned store-conditional, whether it succeeds or fails, invalidates the reservation. A following store-conditional to the same address fails.
- R9: `clear_link`=1 invalidates the reservation at the next edge. It takes priority over a load-linked issued in the same cycle.
- R10: Parameter `SEXT_WORD`=1 (default) picks sign extension of word loads; 0 picks zero extension.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_sc | input | 1 | 0 = load-linked, 1 = store-conditional |
| req_dbl | input | 1 | 1 = doubleword, 0 = word |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | DATA_W | Store data (word in bits 31:0) |
| clear_link | input | 1 | Drop the reservation |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_dbl | output | 1 | Access size, 1 = doubleword |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_rdata | input | DATA_W | Read data, valid the cycle after a read request |
| rsp_valid | output | 1 | Result valid |
| rsp_data | output | DATA_W | Loaded value or success flag |
| exc_pulse | output | 1 | Store address-error, one cycle |
| bad_addr | output | ADDR_W | Captured faulting address |

## Verification
The bench uses the defaults: 32-bit addresses, 64-bit data and sign-extended word loads. With 64-bit data, both alignment masks can be driven side by side at the same reservation. A word store at an address with only bit 2 set then shows that the word check ignores that bit while the doubleword check faults on it. Sign extension puts a negative word loaded next to a poisoned upper half within reach, which exposes any leak of the unused input bits into the result.

// File: rtl/llsc_pkg.sv
package llsc_pkg;
   typedef enum logic {
      OP_LINK_LD = 1'b0,
      OP_COND_ST = 1'b1
   } llsc_op_e;

   localparam int unsigned WORD_ALIGN_BITS = 2;
   localparam int unsigned DBL_ALIGN_BITS  = 3;
endpackage

// File: rtl/llsc_align_chk.sv
module llsc_align_chk #(
   parameter int unsigned ADDR_W = 32
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              dbl,
   output logic              misalign
);
   import llsc_pkg::*;

   localparam logic [ADDR_W-1:0] WORD_MASK = ADDR_W'((1 << WORD_ALIGN_BITS) - 1);
   localparam logic [ADDR_W-1:0] DBL_MASK  = ADDR_W'((1 << DBL_ALIGN_BITS) - 1);

   logic [ADDR_W-1:0] mask;

   always_comb begin
      mask     = dbl ? DBL_MASK : WORD_MASK;
      misalign = |(addr & mask);
   end
endmodule

// File: rtl/llsc_link_reg.sv
module llsc_link_reg #(
   parameter int unsigned ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              set_link,
   input  logic              drop_sc,
   input  logic              drop_ext,
   input  logic [ADDR_W-1:0] addr,
   output logic              hit
);
   logic [ADDR_W-1:0] link_q;
   logic              live_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         link_q <= '0;
         live_q <= 1'b0;
      end else begin
         if (drop_ext) begin
            live_q <= 1'b0;
         end else if (set_link) begin
            live_q <= 1'b1;
         end else if (drop_sc) begin
            live_q <= 1'b0;
         end
         if (set_link && !drop_ext) begin
            link_q <= addr;
         end
      end
   end

   assign hit = live_q && (link_q == addr);
endmodule

// File: rtl/llsc_resp_stage.sv
module llsc_resp_stage #(
   parameter int unsigned ADDR_W    = 32,
   parameter int unsigned DATA_W    = 64,
   parameter bit          SEXT_WORD = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              acc_ll,
   input  logic              acc_sc,
   input  logic              sc_ok,
   input  logic              is_dbl,
   input  logic              fault,
   input  logic [ADDR_W-1:0] fault_addr,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_data,
   output logic              exc_pulse,
   output logic [ADDR_W-1:0] bad_addr
);
   localparam int unsigned WORD_W = DATA_W / 2;

   logic              valid_q, ll_q, dbl_q, flag_q, exc_q;
   logic [ADDR_W-1:0] bad_q;
   logic [DATA_W-1:0] word_ext;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q <= 1'b0;
         ll_q    <= 1'b0;
         dbl_q   <= 1'b0;
         flag_q  <= 1'b0;
         exc_q   <= 1'b0;
         bad_q   <= '0;
      end else begin
         valid_q <= acc_ll || acc_sc;
         ll_q    <= acc_ll;
         dbl_q   <= is_dbl;
         flag_q  <= sc_ok;
         exc_q   <= fault;
         if (fault) begin
            bad_q <= fault_addr;
         end
      end
   end

   generate
      if (SEXT_WORD) begin : g_sext
         assign word_ext = {{WORD_W{mem_rdata[WORD_W-1]}}, mem_rdata[WORD_W-1:0]};
      end else begin : g_zext
         assign word_ext = {{WORD_W{1'b0}}, mem_rdata[WORD_W-1:0]};
      end
   endgenerate

   always_comb begin
      rsp_data = '0;
      if (valid_q) begin
         if (ll_q) begin
            rsp_data = dbl_q ? mem_rdata : word_ext;
         end else begin
            rsp_data = {{(DATA_W-1){1'b0}}, flag_q};
         end
      end
   end

   assign rsp_valid = valid_q;
   assign exc_pulse = exc_q;
   assign bad_addr  = bad_q;
endmodule

// File: rtl/llsc_resv_unit.sv
module llsc_resv_unit #(
   parameter int unsigned ADDR_W    = 32,
   parameter int unsigned DATA_W    = 64,
   parameter bit          SEXT_WORD = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_sc,
   input  logic              req_dbl,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic              clear_link,
   output logic              mem_req,
   output logic              mem_we,
   output logic              mem_dbl,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_data,
   output logic              exc_pulse,
   output logic [ADDR_W-1:0] bad_addr
);
   import llsc_pkg::*;

   generate
      if (ADDR_W < DBL_ALIGN_BITS) begin : g_bad_aw
         $error("llsc_resv_unit: ADDR_W too small for doubleword alignment");
      end
      if ((DATA_W < 16) || ((DATA_W % 2) != 0)) begin : g_bad_dw
         $error("llsc_resv_unit: DATA_W must be even and at least 16");
      end
   endgenerate

   llsc_op_e op;
   logic     is_ll, is_sc, misalign, fault, sc_go, hit, sc_ok;

   assign op    = llsc_op_e'(req_sc);
   assign is_ll = req_valid && (op == OP_LINK_LD);
   assign is_sc = req_valid && (op == OP_COND_ST);

   llsc_align_chk #(.ADDR_W(ADDR_W)) u_align (
      .addr     (req_addr),
      .dbl      (req_dbl),
      .misalign (misalign)
   );

   assign fault = is_sc && misalign;
   assign sc_go = is_sc && !misalign;

   llsc_link_reg #(.ADDR_W(ADDR_W)) u_link (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_link (is_ll),
      .drop_sc  (sc_go),
      .drop_ext (clear_link),
      .addr     (req_addr),
      .hit      (hit)
   );

   assign sc_ok = sc_go && hit;

   assign mem_req   = is_ll || sc_ok;
   assign mem_we    = sc_ok;
   assign mem_dbl   = req_dbl;
   assign mem_addr  = req_addr;
   assign mem_wdata = req_wdata;

   llsc_resp_stage #(
      .ADDR_W    (ADDR_W),
      .DATA_W    (DATA_W),
      .SEXT_WORD (SEXT_WORD)
   ) u_resp (
      .clk        (clk),
      .rst_n      (rst_n),
      .acc_ll     (is_ll),
      .acc_sc     (sc_go),
      .sc_ok      (sc_ok),
      .is_dbl     (req_dbl),
      .fault      (fault),
      .fault_addr (req_addr),
      .mem_rdata  (mem_rdata),
      .rsp_valid  (rsp_valid),
      .rsp_data   (rsp_data),
      .exc_pulse  (exc_pulse),
      .bad_addr   (bad_addr)
   );
endmodule

// File: rtl/llsc_resv_chk.sv
module llsc_resv_chk #(
   parameter int unsigned ADDR_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_sc,
   input logic              req_dbl,
   input logic [ADDR_W-1:0] req_addr,
   input logic              mem_req,
   input logic              mem_we,
   input logic [ADDR_W-1:0] mem_addr,
   input logic              rsp_valid,
   input logic              exc_pulse,
   input logic [ADDR_W-1:0] bad_addr
);
   AST_LL_ISSUES_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_sc) |-> (mem_req && !mem_we && mem_addr == req_addr)); // R2
   AST_LL_RESPONDS: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_sc) |=> rsp_valid); // R2
   AST_WORD_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_sc && !req_dbl && req_addr[1:0] != 2'b00)
      |=> (exc_pulse && !rsp_valid && bad_addr == $past(req_addr))); // R4
   AST_DBL_FAULT_NO_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_sc && req_dbl && req_addr[2:0] != 3'b000) |-> !mem_req); // R5
   AST_WRITE_NEEDS_SC: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> (req_valid && req_sc && mem_req)); // R6
   AST_EXC_NO_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
      exc_pulse |-> !rsp_valid); // R4
endmodule

bind llsc_resv_unit llsc_resv_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .req_sc    (req_sc),
   .req_dbl   (req_dbl),
   .req_addr  (req_addr),
   .mem_req   (mem_req),
   .mem_we    (mem_we),
   .mem_addr  (mem_addr),
   .rsp_valid (rsp_valid),
   .exc_pulse (exc_pulse),
   .bad_addr  (bad_addr)
);

// File: tb/tb_llsc_resv_unit.sv
module tb_llsc_resv_unit;
   localparam int AW = 32;
   localparam int DW = 64;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0, req_sc = 1'b0, req_dbl = 1'b0, clear_link = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic [DW-1:0] req_wdata = '0;
   logic          mem_req, mem_we, mem_dbl;
   logic [AW-1:0] mem_addr;
   logic [DW-1:0] mem_wdata;
   logic [DW-1:0] mem_rdata = '0;
   logic          rsp_valid, exc_pulse;
   logic [DW-1:0] rsp_data;
   logic [AW-1:0] bad_addr;

   int n_chk = 0, n_bad = 0;
   bit done = 1'b0;

   logic [31:0] mem     [0:1023];
   logic [31:0] exp_mem [0:1023];
   logic [AW-1:0] m_link = '0;
   bit            m_live = 1'b0;

   always #2 clk = ~clk;

   llsc_resv_unit dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_sc(req_sc),
      .req_dbl(req_dbl), .req_addr(req_addr), .req_wdata(req_wdata),
      .clear_link(clear_link), .mem_req(mem_req), .mem_we(mem_we),
      .mem_dbl(mem_dbl), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_rdata(mem_rdata), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
      .exc_pulse(exc_pulse), .bad_addr(bad_addr)
   );

   // memory model: one-cycle read latency, word reads carry a poisoned upper half
   always @(posedge clk) begin
      if (mem_req) begin
         if (mem_we) begin
            mem[mem_addr[11:2]] <= mem_wdata[31:0];
            if (mem_dbl) mem[mem_addr[11:2] + 10'd1] <= mem_wdata[63:32];
         end else if (mem_dbl) begin
            mem_rdata <= {mem[mem_addr[11:2] + 10'd1], mem[mem_addr[11:2]]};
         end else begin
            mem_rdata <= {32'hDEAD_BEEF, mem[mem_addr[11:2]]};
         end
      end
   end

   task automatic chk(input bit ok, input string req, input logic [DW-1:0] act,
                      input logic [DW-1:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // one request, checked in its issue cycle and in the following cycle
   task automatic op(input bit sc, input bit dbl, input logic [AW-1:0] addr,
                     input logic [DW-1:0] wd, input bit clr);
      bit mis, ok;
      logic [DW-1:0] exp_rd;
      int unsigned idx;
      @(negedge clk);
      req_valid = 1'b1; req_sc = sc; req_dbl = dbl; req_addr = addr;
      req_wdata = wd; clear_link = clr;
      idx = addr[11:2];
      mis = sc && (dbl ? (addr[2:0] != 0) : (addr[1:0] != 0));
      ok  = sc && !mis && m_live && (m_link == addr);
      exp_rd = dbl ? {exp_mem[idx + 1], exp_mem[idx]}
                   : {{32{exp_mem[idx][31]}}, exp_mem[idx]};
      #1;
      if (!sc) begin
         chk(mem_req && !mem_we && mem_addr == addr && mem_dbl == dbl, "R2 ll read",
             {mem_req, mem_we, mem_dbl}, 3'b101);
      end else if (mis) begin
         chk(!mem_req, dbl ? "R5 dbl fault no access" : "R4 word fault no access",
             mem_req, 0);
      end else if (ok) begin
         chk(mem_req && mem_we && mem_addr == addr && mem_wdata == wd,
             "R6 sc store", {mem_req, mem_we}, 2'b11);
      end else begin
         chk(!mem_req, "R7 failed sc no access", mem_req, 0);
      end
      @(posedge clk); #1;
      if (mis) begin
         chk(exc_pulse && !rsp_valid, dbl ? "R5 exc pulse" : "R4 exc pulse",
             {exc_pulse, rsp_valid}, 2'b10);
         chk(bad_addr == addr, dbl ? "R5 bad addr" : "R4 bad addr", bad_addr, addr);
      end else begin
         chk(rsp_valid && !exc_pulse, "R2 response valid", {rsp_valid, exc_pulse}, 2'b10);
         if (!sc) chk(rsp_data == exp_rd, "R2 R10 ll data", rsp_data, exp_rd);
         else     chk(rsp_data == DW'(ok), ok ? "R6 flag" : "R7 R8 flag", rsp_data, DW'(ok));
      end
      if (ok) begin
         exp_mem[idx] = wd[31:0];
         if (dbl) exp_mem[idx + 1] = wd[63:32];
      end
      if (clr)           m_live = 1'b0;
      else if (!sc)      begin m_live = 1'b1; m_link = addr; end
      else if (!mis)     m_live = 1'b0;
   endtask

   task automatic idle(input bit clr);
      @(negedge clk);
      req_valid = 1'b0; clear_link = clr;
      if (clr) m_live = 1'b0;
      @(negedge clk);
      clear_link = 1'b0;
   endtask

   task automatic t_reset;  // R1
      chk(!rsp_valid && !exc_pulse, "R1 reset outputs", {rsp_valid, exc_pulse}, 0);
      chk(bad_addr == 0, "R1 reset bad addr", bad_addr, 0);
      op(1, 0, 32'h0, 64'h1111, 0);   // SC before any LL fails
      op(1, 1, 32'h0, 64'h2222, 0);
   endtask

   task automatic t_match;  // R2 R3 R6 R10
      op(0, 0, 32'h100, 0, 0);
      op(1, 0, 32'h100, 64'h0000_0000_8765_4321, 0);
      op(0, 0, 32'h100, 0, 0);        // negative word, sign extended
      op(0, 1, 32'h208, 0, 0);
      op(1, 1, 32'h208, 64'hCAFE_F00D_1234_5678, 0);
      op(0, 1, 32'h208, 0, 0);
      idle(0);
   endtask

   task automatic t_mismatch;  // R7 R8
      op(0, 0, 32'h100, 0, 0);
      op(1, 0, 32'h104, 64'h5555, 0);
      op(1, 0, 32'h100, 64'h6666, 0); // reservation gone
      op(0, 0, 32'h104, 0, 0);
      op(0, 0, 32'h100, 0, 0);
      idle(0);
   endtask

   task automatic t_misalign;  // R4 R5
      op(0, 1, 32'h300, 0, 0);
      op(1, 0, 32'h302, 64'h7777, 0);
      op(1, 1, 32'h304, 64'h8888, 0);
      op(1, 1, 32'h301, 64'h9999, 0);
      op(1, 1, 32'h300, 64'h0123_4567_89AB_CDEF, 0); // faults left link intact
      op(0, 1, 32'h300, 0, 0);
      op(1, 0, 32'h304, 64'hAAAA, 0); // word aligned, bit 2 set: no fault
      idle(0);
   endtask

   task automatic t_clear;  // R9
      op(0, 0, 32'h400, 0, 0);
      idle(1);
      op(1, 0, 32'h400, 64'hBBBB, 0);
      op(0, 0, 32'h400, 0, 1);        // clear beats same-cycle LL
      op(1, 0, 32'h400, 64'hCCCC, 0);
      op(0, 0, 32'h400, 0, 0);
      idle(0);
   endtask

   task automatic t_b2b;  // R3 R6 R8
      op(0, 0, 32'h500, 0, 0);
      op(1, 0, 32'h500, 64'hFFFF_FFFF_7000_0001, 0);
      op(1, 0, 32'h500, 64'h1234, 0);
      op(0, 0, 32'h508, 0, 0);
      op(0, 0, 32'h50C, 0, 0);        // second LL replaces the first
      op(1, 0, 32'h508, 64'h4321, 0);
      op(0, 0, 32'h50C, 0, 0);
      op(1, 0, 32'h50C, 64'h0000_0000_FFFF_FFFE, 0);
      op(0, 0, 32'h50C, 0, 0);
      op(0, 0, 32'h500, 0, 0);
      idle(0);
   endtask

   initial begin
      for (int i = 0; i < 1024; i++) begin
         mem[i]     = 32'h3C00_0000 ^ (i * 32'h0101_0103);
         exp_mem[i] = 32'h3C00_0000 ^ (i * 32'h0101_0103);
      end
      repeat (3) @(posedge clk);
      #1;
      t_reset_pre();
      @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_match();
      t_mismatch();
      t_misalign();
      t_clear();
      t_b2b();
      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   task automatic t_reset_pre;  // R1 during reset
      chk(!rsp_valid && !exc_pulse && !mem_req, "R1 held in reset",
          {rsp_valid, exc_pulse, mem_req}, 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule